// File: doc/BRIEF.md
# Debug Access Security Lock

This block stands between two external access paths (a serial debug port and a parallel programming port) and the on-chip resources they reach: flash, SRAM, core registers and peripherals. A single persistent lock flag decides whether those requests are granted. While the flag is set, every external request is refused. Read data returned on a refused read is forced to zero, and a refused read raises a one-cycle denial pulse. A refused write never reaches the target. Accesses made by the CPU itself do not pass through this block and are never gated.

The lock flag is bit 0 of a small bank of option bits. Non-volatility is modelled by presetting the bank at reset, with bit 0 taken from `lock_init`. The option command logic can set any in-range bit. It can clear any in-range bit except bit 0. The only way to drop the lock is a rising edge on the erase pin, followed by a full-erase-done pulse from the flash array while the pin is still high.

Top module: `debug_lock_gate`

## Requirements
- R1: During and right after reset, `lock_o` equals `lock_init`, all option bits other than bit 0 are zero, and both denial outputs are low.
- R2: While `lock_o` is high, `dbg_gnt` and `prg_gnt` are low and `dbg_rdata` and `prg_rdata` are zero, whatever the requests are.
- R3: While `lock_o` is low, each grant equals its request (combinationally) and each rdata equals its target read data.
- R4: A read request (`req`=1, `we`=0) presented while locked raises that port's deny output in the following cycle for exactly that cycle. A write request while locked raises no deny and produces no grant.
- R5: A command with `opt_cmd_valid`=1, `opt_cmd_set`=1 and `opt_cmd_idx`=0 sets the lock at that clock edge. `lock_o` is high in the next cycle.
- R6: A clear command (`opt_cmd_set`=0) for index 0 never changes the lock. Set and clear commands for indices 1 to NUM_OPT-1 set or clear `opt_bits_o[idx]` at the edge. Indices of NUM_OPT or above change nothing.
- R7: A rising edge of `erase_pin` arms the erase sequence at the edge where it is first seen high. A later edge that samples `erase_done`=1 with `erase_pin` still high and the sequence armed clears the lock, and consumes the arming.
- R8: `erase_done` has no effect when the sequence is not armed. A low `erase_pin` disarms the sequence. A pin held high with no new rising edge cannot clear the lock a second time.
- R9: When a set command for index 0 and a valid erase clear fall on the same edge, the lock stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_init | input | 1 | Preset value for the lock bit during reset |
| opt_cmd_valid | input | 1 | Option bit command strobe |
| opt_cmd_set | input | 1 | 1 = set the bit, 0 = clear the bit |
| opt_cmd_idx | input | IDX_W | Option bit index |
| erase_pin | input | 1 | External erase pin, active high |
| erase_done | input | 1 | Full flash erase completed pulse |
| dbg_req | input | 1 | Debug port access request |
| dbg_we | input | 1 | Debug port write enable |
| dbg_tgt_rdata | input | DATA_W | Read data from target for debug port |
| dbg_gnt | output | 1 | Debug access granted, strobes the target |
| dbg_rdata | output | DATA_W | Read data to debug port |
| dbg_deny | output | 1 | Debug read refused pulse |
| prg_req | input | 1 | Programming port access request |
| prg_we | input | 1 | Programming port write enable |
| prg_tgt_rdata | input | DATA_W | Read data from target for programming port |
| prg_gnt | output | 1 | Programming access granted |
| prg_rdata | output | DATA_W | Read data to programming port |
| prg_deny | output | 1 | Programming read refused pulse |
| lock_o | output | 1 | Current lock state (option bit 0) |
| opt_bits_o | output | NUM_OPT | Current option bits |

## Verification
A corrupted lock bit shows at once: in the same cycle it turns every grant and read data word on both ports into the wrong value, so any request exposes it. A stale arming flag or a stale pin history stays hidden until the next `erase_done` pulse. It then shows one cycle later, as `lock_o` dropping when it should hold or holding when it should drop. A wrong deny register shows in the cycle after the offending read. Random traffic with sparse erase pulses, checked against a cycle model, gives every one of these faults a chance to reach the ports.

// File: rtl/debug_lock_gate.sv
module debug_lock_gate #(
  parameter int NUM_OPT = 8,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_init,
  input  logic              opt_cmd_valid,
  input  logic              opt_cmd_set,
  input  logic [IDX_W-1:0]  opt_cmd_idx,
  input  logic              erase_pin,
  input  logic              erase_done,
  input  logic              dbg_req,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_tgt_rdata,
  output logic              dbg_gnt,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_deny,
  input  logic              prg_req,
  input  logic              prg_we,
  input  logic [DATA_W-1:0] prg_tgt_rdata,
  output logic              prg_gnt,
  output logic [DATA_W-1:0] prg_rdata,
  output logic              prg_deny,
  output logic              lock_o,
  output logic [NUM_OPT-1:0] opt_bits_o
);
  localparam int NPORT = 2;

  logic [NUM_OPT-1:0] opt_q, opt_d;
  logic pin_q, armed_q, erase_clr;

  assign lock_o     = opt_q[0];
  assign opt_bits_o = opt_q;

  assign erase_clr = erase_done & erase_pin & armed_q;

  always_comb begin
    opt_d = opt_q;
    if (erase_clr) opt_d[0] = 1'b0;
    for (int i = 0; i < NUM_OPT; i++) begin
      if (opt_cmd_valid && (int'(opt_cmd_idx) == i)) begin
        if (opt_cmd_set) opt_d[i] = 1'b1;
        else if (i != 0) opt_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q    <= '0;
      opt_q[0] <= lock_init;
      pin_q    <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      opt_q <= opt_d;
      pin_q <= erase_pin;
      if (!erase_pin)          armed_q <= 1'b0;
      else if (!pin_q)         armed_q <= 1'b1;
      else if (erase_done)     armed_q <= 1'b0;
    end
  end

  logic [NPORT-1:0] req, we, gnt, deny_q;
  logic [DATA_W-1:0] tgt_rd [NPORT];
  logic [DATA_W-1:0] rd     [NPORT];

  assign req       = {prg_req, dbg_req};
  assign we        = {prg_we, dbg_we};
  assign tgt_rd[0] = dbg_tgt_rdata;
  assign tgt_rd[1] = prg_tgt_rdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign gnt[p] = req[p] & ~lock_o;
    assign rd[p]  = lock_o ? '0 : tgt_rd[p];
    always_ff @(posedge clk) begin
      if (!rst_n) deny_q[p] <= 1'b0;
      else        deny_q[p] <= req[p] & ~we[p] & lock_o;
    end
  end

  assign dbg_gnt   = gnt[0];
  assign prg_gnt   = gnt[1];
  assign dbg_rdata = rd[0];
  assign prg_rdata = rd[1];
  assign dbg_deny  = deny_q[0];
  assign prg_deny  = deny_q[1];
endmodule

// File: rtl/debug_lock_gate_chk.sv
module debug_lock_gate_chk #(
  parameter int NUM_OPT = 8,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opt_cmd_valid,
  input logic              opt_cmd_set,
  input logic [IDX_W-1:0]  opt_cmd_idx,
  input logic              erase_pin,
  input logic              erase_done,
  input logic              dbg_req,
  input logic              dbg_we,
  input logic              dbg_gnt,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic              dbg_deny,
  input logic              prg_req,
  input logic              prg_we,
  input logic              prg_gnt,
  input logic [DATA_W-1:0] prg_rdata,
  input logic              prg_deny,
  input logic              lock_o
);
  AST_LOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (!dbg_gnt && !prg_gnt)); // R2
  AST_LOCKED_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (dbg_rdata == '0 && prg_rdata == '0)); // R2
  AST_OPEN_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> (dbg_gnt == dbg_req && prg_gnt == prg_req)); // R3
  AST_DBG_DENY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_deny |-> $past(dbg_req && !dbg_we && lock_o)); // R4
  AST_PRG_DENY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    prg_deny |-> $past(prg_req && !prg_we && lock_o)); // R4
  AST_LOCK_RISE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(opt_cmd_valid && opt_cmd_set && opt_cmd_idx == '0)); // R5
  AST_LOCK_FALL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(erase_done && erase_pin)); // R7
endmodule

bind debug_lock_gate debug_lock_gate_chk #(
  .NUM_OPT(NUM_OPT), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .opt_cmd_valid(opt_cmd_valid), .opt_cmd_set(opt_cmd_set), .opt_cmd_idx(opt_cmd_idx),
  .erase_pin(erase_pin), .erase_done(erase_done),
  .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_gnt(dbg_gnt), .dbg_rdata(dbg_rdata), .dbg_deny(dbg_deny),
  .prg_req(prg_req), .prg_we(prg_we), .prg_gnt(prg_gnt), .prg_rdata(prg_rdata), .prg_deny(prg_deny),
  .lock_o(lock_o)
);

// File: tb/debug_lock_gate_test.sv
module debug_lock_gate_test;
  localparam int NUM_OPT = 8;
  localparam int IDX_W   = 4;
  localparam int DATA_W  = 32;

  logic clk = 0, rst_n = 0, lock_init = 0;
  logic opt_cmd_valid = 0, opt_cmd_set = 0;
  logic [IDX_W-1:0] opt_cmd_idx = '0;
  logic erase_pin = 0, erase_done = 0;
  logic dbg_req = 0, dbg_we = 0, prg_req = 0, prg_we = 0;
  logic [DATA_W-1:0] dbg_tgt_rdata = '0, prg_tgt_rdata = '0;
  logic dbg_gnt, prg_gnt, dbg_deny, prg_deny, lock_o;
  logic [DATA_W-1:0] dbg_rdata, prg_rdata;
  logic [NUM_OPT-1:0] opt_bits_o;

  int checks = 0, errors = 0;
  logic [NUM_OPT-1:0] m_opt;
  logic m_pin_q, m_armed, m_dd, m_pd;

  always #2 clk = ~clk;

  debug_lock_gate #(.NUM_OPT(NUM_OPT), .IDX_W(IDX_W), .DATA_W(DATA_W)) uut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic clr;
    #1;
    check("R2/R3 dbg_gnt", dbg_gnt, dbg_req & ~m_opt[0]);
    check("R2/R3 prg_gnt", prg_gnt, prg_req & ~m_opt[0]);
    check("R2/R3 dbg_rdata", dbg_rdata, m_opt[0] ? '0 : dbg_tgt_rdata);
    check("R2/R3 prg_rdata", prg_rdata, m_opt[0] ? '0 : prg_tgt_rdata);
    @(posedge clk);
    m_dd = dbg_req & ~dbg_we & m_opt[0];
    m_pd = prg_req & ~prg_we & m_opt[0];
    clr  = erase_done & erase_pin & m_armed;
    if (clr) m_opt[0] = 1'b0;
    if (opt_cmd_valid && int'(opt_cmd_idx) < NUM_OPT) begin
      if (opt_cmd_set) m_opt[opt_cmd_idx] = 1'b1;
      else if (opt_cmd_idx != 0) m_opt[opt_cmd_idx] = 1'b0;
    end
    if (!erase_pin) m_armed = 0;
    else if (!m_pin_q) m_armed = 1;
    else if (erase_done) m_armed = 0;
    m_pin_q = erase_pin;
    #1;
    check("R5/R6/R7/R8/R9 lock_o", lock_o, m_opt[0]);
    check("R6 opt_bits_o", opt_bits_o, m_opt);
    check("R4 dbg_deny", dbg_deny, m_dd);
    check("R4 prg_deny", prg_deny, m_pd);
    @(negedge clk);
    opt_cmd_valid = 0; erase_done = 0;
  endtask

  task automatic do_reset(logic init);
    @(negedge clk);
    rst_n = 0; lock_init = init;
    opt_cmd_valid = 0; erase_pin = 0; erase_done = 0;
    dbg_req = 0; prg_req = 0;
    repeat (3) @(negedge clk);
    check("R1 lock during reset", lock_o, init);
    rst_n = 1;
    m_opt = '0; m_opt[0] = init; m_pin_q = 0; m_armed = 0; m_dd = 0; m_pd = 0;
    #1;
    check("R1 lock after reset", lock_o, init);
    check("R1 other option bits", opt_bits_o[NUM_OPT-1:1], '0);
    check("R1 deny low", {dbg_deny, prg_deny}, 2'b00);
  endtask

  task automatic cmd(logic set, int idx);
    opt_cmd_valid = 1; opt_cmd_set = set; opt_cmd_idx = IDX_W'(idx);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset(1'b0);
    // R3 open reads and writes
    dbg_req = 1; dbg_tgt_rdata = 32'hCAFE_0001; prg_req = 1; prg_we = 1;
    step();
    // R5 lock via set command
    cmd(1, 0); step();
    check("R5 locked", lock_o, 1);
    // R4 denied read then denied write
    dbg_req = 1; dbg_we = 0; prg_req = 1; prg_we = 1; step();
    check("R4 read deny pulse", dbg_deny, 1);
    check("R4 write no deny", prg_deny, 0);
    dbg_req = 0; prg_req = 0; step();
    check("R4 pulse ends", dbg_deny, 0);
    // R6 clear of bit 0 ignored, other bits work, out of range ignored
    cmd(0, 0); step();
    check("R6 clear idx0 ignored", lock_o, 1);
    cmd(1, 3); step();
    check("R6 set idx3", opt_bits_o[3], 1);
    cmd(0, 3); step();
    check("R6 clear idx3", opt_bits_o[3], 0);
    cmd(1, 12); step();
    check("R6 out of range", opt_bits_o, 8'h01);
    // R8 done without arming
    erase_done = 1; step();
    check("R8 unarmed done", lock_o, 1);
    // R7 rise then done
    erase_pin = 1; step(); step();
    erase_done = 1; step();
    check("R7 erase clears lock", lock_o, 0);
    // R8 pin still high, relock, second done ignored
    cmd(1, 0); step();
    erase_done = 1; step();
    check("R8 no re-arm", lock_o, 1);
    // R8 pin low disarms
    erase_pin = 0; step(); erase_pin = 1; step(); erase_pin = 0; step();
    erase_done = 1; step();
    check("R8 pin low ignored", lock_o, 1);
    // R9 set and erase on same edge
    erase_pin = 1; step();
    erase_done = 1; cmd(1, 0); step();
    check("R9 set wins", lock_o, 1);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      dbg_req = 1'($urandom); dbg_we = 1'($urandom);
      prg_req = 1'($urandom); prg_we = 1'($urandom);
      dbg_tgt_rdata = $urandom; prg_tgt_rdata = $urandom;
      if ($urandom_range(0, 7) == 0) cmd(1'($urandom), $urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) erase_pin = ~erase_pin;
      erase_done = ($urandom_range(0, 9) == 0);
      step();
    end
    // R1 preset locked
    do_reset(1'b1);
    dbg_req = 1; dbg_we = 0; step();
    check("R1 preset lock blocks", dbg_deny, 1);
    summary();
  end
endmodule